// File: doc/BRIEF.md
# Protection Region CSR Bank

This block holds the control state for a fixed set of physical memory protection entries. Each entry has an 8-bit configuration byte and an XLEN-wide address register. A core reaches the block through one CSR port: a one-cycle write pulse with a selector, an index and data. Read data is combinational from the selector and index. Configuration bytes are packed into XLEN-wide configuration CSRs. Address registers are reached one entry per index.

Writes are filtered by lock state. An entry with its lock bit set accepts no further writes to either of its registers. When that locked entry uses top-of-range matching, the entry directly below it is frozen as well, because that lower entry's address supplies the base of the range. A configuration CSR write is judged lane by lane, so one write can update some bytes and drop others. All entries' registers go out in parallel to downstream range-decode logic, together with the count of entries whose match mode is not OFF.

Top module: `prc_csr_bank`

## Requirements
- R1: While reset is asserted and just after it, every configuration byte, every address register, the active count and the read data for any index are zero.
- R2: A configuration CSR with index r holds the bytes of entries 4r through 4r+XLEN/8-1, with byte k of that CSR at bits 8k+7:8k. Both reads and writes use this packing.
- R3: An address write (selector 1) to an unlocked implemented entry i stores the full data word, and a read with selector 1 and index i returns that word.
- R4: When bit 7 (lock) of entry i's configuration byte is set, configuration and address writes to entry i are discarded.
- R5: Entry i is also write-protected when entry i+1 has its lock bit set and its match mode, bits 4:3, equals 01 (top-of-range). A locked neighbour in any other mode (00 off, 10 four-byte, 11 naturally aligned power of two) gives no protection. The topmost entry has no upper neighbour.
- R6: Each byte lane of a configuration write is judged on its own, against the lock state before the write. Unprotected lanes update in the same write in which protected lanes are dropped.
- R7: Entries with an index at or above the implemented count read as zero. Writes aimed at them change nothing, both for address indices and for configuration lanes.
- R8: When XLEN is 64, a write to an odd-numbered configuration CSR is ignored entirely.
- R9: The active count equals the number of entries whose match mode (bits 4:3) is not 00.
- R10: An accepted write is visible on the entry outputs, the active count and the read data from the clock edge that samples it. Until then the old values remain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | One-cycle write strobe |
| csr_sel_i | input | 1 | 0 selects the configuration CSRs, 1 selects the address registers |
| csr_idx_i | input | IDX_W | CSR index (configuration row or entry number) |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Combinational read data for the selector and index |
| ent_cfg_o | output | NUM_ENT*8 | All configuration bytes, entry i at bits 8i+7:8i |
| ent_addr_o | output | NUM_ENT*XLEN | All address registers, entry i at slice i*XLEN |
| active_cnt_o | output | $clog2(NUM_ENT+1) | Number of entries whose match mode is not off |

## Verification
The assertions take for granted that the selector, index and data are stable around the sampling edge, and that a write strobe lasts exactly one cycle per intended write. The stability checks compare state across the very edge that takes the strobe. The bench drives every input on the falling edge, keeps the strobe high for one cycle per write, and holds the selector and index steady while it samples read data. It covers locks on entries with and without top-of-range mode, on the topmost entry, odd rows at XLEN 64, and indices past the implemented range, so every frozen-state assertion is exercised.

// File: rtl/prc_pkg.sv
package prc_pkg;

    localparam int CFG_W    = 8;
    localparam int LOCK_BIT = 7;
    localparam int MODE_LSB = 3;
    localparam int ROW_STEP = 4;

    localparam logic SEL_CFG  = 1'b0;
    localparam logic SEL_ADDR = 1'b1;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'b00,
        MATCH_TOR   = 2'b01,
        MATCH_NA4   = 2'b10,
        MATCH_NAPOT = 2'b11
    } match_e;

    function automatic match_e cfg_mode(input logic [CFG_W-1:0] b);
        return match_e'(b[MODE_LSB +: 2]);
    endfunction

endpackage

// File: rtl/prc_lock_eval.sv
module prc_lock_eval
    import prc_pkg::*;
#(
    parameter int NUM_ENT = 16
) (
    input  logic [NUM_ENT*CFG_W-1:0] cfg_i,
    output logic [NUM_ENT-1:0]       frozen_o
);

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        logic own_lock;
        assign own_lock = cfg_i[g*CFG_W + LOCK_BIT];
        if (g == NUM_ENT - 1) begin : g_top
            assign frozen_o[g] = own_lock;
        end else begin : g_mid
            logic up_lock;
            logic up_tor;
            assign up_lock = cfg_i[(g+1)*CFG_W + LOCK_BIT];
            assign up_tor  = (cfg_mode(cfg_i[(g+1)*CFG_W +: CFG_W]) == MATCH_TOR);
            assign frozen_o[g] = own_lock | (up_lock & up_tor);
        end
    end

endmodule

// File: rtl/prc_active_count.sv
module prc_active_count
    import prc_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int CNT_W   = $clog2(NUM_ENT + 1)
) (
    input  logic [NUM_ENT*CFG_W-1:0] cfg_i,
    output logic [CNT_W-1:0]         cnt_o
);

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (cfg_mode(cfg_i[i*CFG_W +: CFG_W]) != MATCH_OFF) begin
                cnt_o = cnt_o + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/prc_read_mux.sv
module prc_read_mux
    import prc_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int XLEN    = 32,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_ENT*CFG_W-1:0] cfg_i,
    input  logic [NUM_ENT*XLEN-1:0]  addr_i,
    input  logic                     sel_i,
    input  logic [IDX_W-1:0]         idx_i,
    output logic [XLEN-1:0]          rdata_o
);

    localparam int LANES = XLEN / CFG_W;
    localparam int EB    = $clog2(NUM_ENT);

    always_comb begin
        int ent;
        rdata_o = '0;
        ent     = 0;
        if (sel_i == SEL_ADDR) begin
            ent = int'(idx_i);
            if (ent < NUM_ENT) begin
                rdata_o = addr_i[ent[EB-1:0]*XLEN +: XLEN];
            end
        end else begin
            for (int k = 0; k < LANES; k++) begin
                ent = int'(idx_i) * ROW_STEP + k;
                if (ent < NUM_ENT) begin
                    rdata_o[k*CFG_W +: CFG_W] = cfg_i[ent[EB-1:0]*CFG_W +: CFG_W];
                end
            end
        end
    end

endmodule

// File: rtl/prc_csr_bank.sv
module prc_csr_bank
    import prc_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int XLEN    = 32,
    parameter int IDX_W   = 6,
    parameter int CNT_W   = $clog2(NUM_ENT + 1)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     csr_we_i,
    input  logic                     csr_sel_i,
    input  logic [IDX_W-1:0]         csr_idx_i,
    input  logic [XLEN-1:0]          csr_wdata_i,
    output logic [XLEN-1:0]          csr_rdata_o,
    output logic [NUM_ENT*CFG_W-1:0] ent_cfg_o,
    output logic [NUM_ENT*XLEN-1:0]  ent_addr_o,
    output logic [CNT_W-1:0]         active_cnt_o
);

    localparam int LANES    = XLEN / CFG_W;
    localparam int EB       = $clog2(NUM_ENT);
    localparam bit ODD_SKIP = (XLEN == 64);

    typedef struct packed {
        logic [NUM_ENT-1:0][CFG_W-1:0] cfg;
        logic [NUM_ENT-1:0][XLEN-1:0]  addr;
    } bank_t;

    bank_t              s_d, s_q;
    logic [NUM_ENT-1:0] frozen;

    prc_lock_eval #(.NUM_ENT(NUM_ENT)) u_lock (
        .cfg_i    (s_q.cfg),
        .frozen_o (frozen)
    );

    prc_active_count #(.NUM_ENT(NUM_ENT), .CNT_W(CNT_W)) u_cnt (
        .cfg_i (s_q.cfg),
        .cnt_o (active_cnt_o)
    );

    prc_read_mux #(.NUM_ENT(NUM_ENT), .XLEN(XLEN), .IDX_W(IDX_W)) u_rd (
        .cfg_i   (s_q.cfg),
        .addr_i  (s_q.addr),
        .sel_i   (csr_sel_i),
        .idx_i   (csr_idx_i),
        .rdata_o (csr_rdata_o)
    );

    // Next-state: lock verdicts all come from the pre-write state.
    always_comb begin
        int  ent;
        logic row_ok;
        s_d    = s_q;
        ent    = 0;
        row_ok = !(ODD_SKIP && csr_idx_i[0]);
        if (csr_we_i) begin
            if (csr_sel_i == SEL_CFG) begin
                if (row_ok) begin
                    for (int k = 0; k < LANES; k++) begin
                        ent = int'(csr_idx_i) * ROW_STEP + k;
                        if (ent < NUM_ENT && !frozen[ent[EB-1:0]]) begin
                            s_d.cfg[ent[EB-1:0]] = csr_wdata_i[k*CFG_W +: CFG_W];
                        end
                    end
                end
            end else begin
                ent = int'(csr_idx_i);
                if (ent < NUM_ENT && !frozen[ent[EB-1:0]]) begin
                    s_d.addr[ent[EB-1:0]] = csr_wdata_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ent_cfg_o  = s_q.cfg;
    assign ent_addr_o = s_q.addr;

endmodule

// File: rtl/prc_csr_bank_chk.sv
module prc_csr_bank_chk
    import prc_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int XLEN    = 32,
    parameter int IDX_W   = 6,
    parameter int CNT_W   = $clog2(NUM_ENT + 1)
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     csr_we_i,
    input logic                     csr_sel_i,
    input logic [IDX_W-1:0]         csr_idx_i,
    input logic [XLEN-1:0]          csr_rdata_o,
    input logic [NUM_ENT*CFG_W-1:0] ent_cfg_o,
    input logic [NUM_ENT*XLEN-1:0]  ent_addr_o,
    input logic [CNT_W-1:0]         active_cnt_o
);

    logic [CNT_W-1:0] tally;
    always_comb begin
        tally = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            tally = tally + CNT_W'(ent_cfg_o[i*CFG_W + MODE_LSB +: 2] != 2'b00);
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |-> (ent_cfg_o == '0 && ent_addr_o == '0 && active_cnt_o == '0));

    // R9
    active_tally_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_cnt_o == tally);

    // R7
    oob_addr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && csr_sel_i == SEL_ADDR && int'(csr_idx_i) >= NUM_ENT)
        |=> $stable(ent_addr_o) && $stable(ent_cfg_o));

    if (XLEN == 64) begin : g_odd
        // R8
        odd_row_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (csr_we_i && csr_sel_i == SEL_CFG && csr_idx_i[0])
            |=> $stable(ent_cfg_o) && $stable(ent_addr_o));
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        // R4
        own_lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ent_cfg_o[g*CFG_W + LOCK_BIT]
            |=> $stable(ent_cfg_o[g*CFG_W +: CFG_W]) && $stable(ent_addr_o[g*XLEN +: XLEN]));
        if (g < NUM_ENT - 1) begin : g_nb
            // R5
            tor_base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (ent_cfg_o[(g+1)*CFG_W + LOCK_BIT] &&
                 ent_cfg_o[(g+1)*CFG_W + MODE_LSB +: 2] == 2'b01)
                |=> $stable(ent_cfg_o[g*CFG_W +: CFG_W]) && $stable(ent_addr_o[g*XLEN +: XLEN]));
        end
    end

endmodule

bind prc_csr_bank prc_csr_bank_chk #(
    .NUM_ENT(NUM_ENT), .XLEN(XLEN), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .csr_we_i     (csr_we_i),
    .csr_sel_i    (csr_sel_i),
    .csr_idx_i    (csr_idx_i),
    .csr_rdata_o  (csr_rdata_o),
    .ent_cfg_o    (ent_cfg_o),
    .ent_addr_o   (ent_addr_o),
    .active_cnt_o (active_cnt_o)
);

// File: tb/sim_prc_csr_bank.sv
module sim_prc_csr_bank;

    localparam int N     = 16;
    localparam int XL    = 64;
    localparam int IW    = 6;
    localparam int CW    = $clog2(N + 1);
    localparam int LN    = XL / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic          sel = 1'b0;
    logic [IW-1:0] idx = '0;
    logic [XL-1:0] wd = '0;
    logic [XL-1:0] rd;
    logic [N*8-1:0]  cfg_o;
    logic [N*XL-1:0] addr_o;
    logic [CW-1:0]   cnt_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    prc_csr_bank #(.NUM_ENT(N), .XLEN(XL), .IDX_W(IW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_sel_i(sel),
        .csr_idx_i(idx), .csr_wdata_i(wd), .csr_rdata_o(rd),
        .ent_cfg_o(cfg_o), .ent_addr_o(addr_o), .active_cnt_o(cnt_o)
    );

    // Behavioural reference
    logic [7:0]    m_cfg  [N];
    logic [XL-1:0] m_addr [N];

    function automatic bit m_prot(int e);
        if (m_cfg[e][7]) return 1;
        if (e + 1 < N && m_cfg[e+1][7] && m_cfg[e+1][4:3] == 2'b01) return 1;
        return 0;
    endfunction

    function automatic logic [XL-1:0] m_read(logic s, int i);
        logic [XL-1:0] v = '0;
        if (s) begin
            if (i < N) v = m_addr[i];
        end else begin
            for (int k = 0; k < LN; k++)
                if (i*4 + k < N) v[k*8 +: 8] = m_cfg[i*4 + k];
        end
        return v;
    endfunction

    function automatic int m_count();
        int c = 0;
        for (int e = 0; e < N; e++) if (m_cfg[e][4:3] != 2'b00) c++;
        return c;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < N; e++) begin m_cfg[e] = 8'h0; m_addr[e] = '0; end
        end else if (we) begin
            bit prot [N];
            for (int e = 0; e < N; e++) prot[e] = m_prot(e);
            if (!sel) begin
                if (!(XL == 64 && idx[0]))
                    for (int k = 0; k < LN; k++)
                        if (int'(idx)*4 + k < N && !prot[int'(idx)*4 + k])
                            m_cfg[int'(idx)*4 + k] = wd[k*8 +: 8];
            end else if (int'(idx) < N && !prot[int'(idx)]) begin
                m_addr[int'(idx)] = wd;
            end
        end
    end

    task automatic check(string tag, logic [XL-1:0] act, logic [XL-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R10: every cycle, outputs match the reference after the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            for (int e = 0; e < N; e++) begin
                check("R10 cfg", XL'(cfg_o[e*8 +: 8]), XL'(m_cfg[e]));
                check("R10 addr", addr_o[e*XL +: XL], m_addr[e]);
            end
            check("R10 count", XL'(cnt_o), XL'(m_count()));
            check("R10 rdata", rd, m_read(sel, int'(idx)));
        end
    end

    task automatic wr(logic s, int i, logic [XL-1:0] d);
        @(negedge clk);
        we = 1'b1; sel = s; idx = IW'(i); wd = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rdchk(string tag, logic s, int i, logic [XL-1:0] exp);
        @(negedge clk);
        sel = s; idx = IW'(i);
        #1;
        check(tag, rd, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cfg out", XL'(cfg_o), '0);
        check("R1 count", XL'(cnt_o), '0);
        rdchk("R1 rdata", 1'b0, 0, '0);
        rst_n = 1'b1;

        wr(1'b0, 0, 64'h0000_0000_1890_0B07);
        rdchk("R2 row0 pack", 1'b0, 0, 64'h0000_0000_1890_0B07);
        check("R2 entry3 byte", XL'(cfg_o[3*8 +: 8]), 64'h18);
        check("R9 count three", XL'(cnt_o), 64'd3);

        wr(1'b1, 3, 64'h1234_5678_9ABC_DEF0);
        rdchk("R3 addr3", 1'b1, 3, 64'h1234_5678_9ABC_DEF0);

        wr(1'b1, 2, 64'hAAAA);
        rdchk("R4 addr2 locked", 1'b1, 2, '0);
        wr(1'b0, 0, 64'h0000_0000_1800_0B07);
        rdchk("R4 cfg2 locked", 1'b0, 0, 64'h0000_0000_1890_0B07);

        wr(1'b1, 5, 64'h55);
        wr(1'b0, 0, 64'h0088_0000_1890_0B07);
        wr(1'b1, 5, 64'h77);
        rdchk("R5 addr5 below tor lock", 1'b1, 5, 64'h55);
        wr(1'b1, 6, 64'h66);
        rdchk("R4 addr6 locked", 1'b1, 6, '0);

        wr(1'b0, 0, 64'h1111_1111_1111_1111);
        rdchk("R6 lane mix", 1'b0, 0, 64'h1188_0011_1190_1111);
        check("R9 count seven", XL'(cnt_o), 64'd7);

        wr(1'b0, 2, 64'h0000_0000_0000_9800);
        wr(1'b1, 8, 64'h42);
        rdchk("R5 napot lock no neighbour", 1'b1, 8, 64'h42);
        wr(1'b1, 9, 64'h43);
        rdchk("R4 addr9 locked", 1'b1, 9, '0);

        wr(1'b0, 2, 64'h8800_0000_0000_9800);
        wr(1'b1, 14, 64'hE);
        rdchk("R5 below topmost", 1'b1, 14, '0);
        wr(1'b1, 15, 64'hF);
        rdchk("R5 topmost own lock", 1'b1, 15, '0);
        check("R9 count nine", XL'(cnt_o), 64'd9);

        wr(1'b0, 1, '1);
        rdchk("R8 odd row0 kept", 1'b0, 0, 64'h1188_0011_1190_1111);
        rdchk("R8 odd row2 kept", 1'b0, 2, 64'h8800_0000_0000_9800);
        check("R8 count kept", XL'(cnt_o), 64'd9);
        rdchk("R2 row1 read", 1'b0, 1, 64'h0000_9800_1188_0011);

        wr(1'b1, 16, 64'hDEAD);
        rdchk("R7 addr16 zero", 1'b1, 16, '0);
        wr(1'b0, 4, '1);
        rdchk("R7 row4 zero", 1'b0, 4, '0);
        rdchk("R7 row0 unchanged", 1'b0, 0, 64'h1188_0011_1190_1111);

        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset cfg", XL'(cfg_o), '0);
        check("R1 reset addr3", addr_o[3*XL +: XL], '0);
        check("R1 reset count", XL'(cnt_o), '0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule